// File: doc/BRIEF.md
# Byte-Addressed Control and Status Register Bank

This block gives a device a small set of registers that a processor reaches over an 8-bit register bus made of an address, a write enable, write data and registered read data. It holds two storage registers that the processor programs and the device consumes, one status register that the device drives and the processor only reads, and one event-flag register that collects one-cycle pulses from the device until the processor clears them.

Registers wider than one byte take consecutive addresses, most significant byte first. Storage register A is written atomically: its upper bytes collect in a shadow register and the whole value takes effect in one cycle when its least significant byte is written. It carries low alignment bits that read as zero on the device side, and the device may load it directly. Storage register B is written byte by byte with immediate effect. Each storage register gives the device a one-cycle strobe per processor write so the device can react.

With default parameters the map is: address 0 = A bits 15:8, 1 = A bits 7:0, 2 = B bits 11:8 (upper nibble of the byte reads 0), 3 = B bits 7:0, 4/5/6 = status bits 23:16/15:8/7:0, 7 = event flags, 8 to 15 unmapped.

Top module: `csr_bank`

## Requirements
- R1: After reset `a_value` is 0x12340 (reset value 0x1234 above four zero alignment bits), `b_value` is 0x0A5, both strobes are 0, all event flags are 0 and `bus_rdata` is 0.
- R2: `bus_rdata` shows, one clock after an address is presented, the byte stored at that address in the map above, with the most significant byte of each register at its lowest address.
- R3: Addresses 8 to 15 read as 0x00, and writes to them change no output.
- R4: A write to address 0 changes only the shadow; `a_value` keeps its value until address 1 is written, when the CPU part of `a_value` becomes {shadow byte, written byte} in one step.
- R5: `a_wstb` is high for exactly the one cycle after a write to address 1 and is never high for a write to address 0.
- R6: Bits 3:0 of `a_value` are always zero; CPU and device data appear in bits 19:4.
- R7: A write to address 2 sets `b_value[11:8]` to the low nibble of the byte, a write to address 3 sets `b_value[7:0]`, each taking effect on the next cycle, and `b_wstb` pulses for one cycle after each of these writes.
- R8: With `a_dev_we` high and no write to address 1, `a_value[19:4]` takes `a_dev_din` on the next cycle, without a strobe.
- R9: When a write to address 1 and `a_dev_we` occur in the same cycle, the processor value is taken and `a_dev_din` is dropped.
- R10: Addresses 4 to 6 return the live `status_i` most significant byte first; writes to them change neither the status read-back nor any storage register.
- R11: A high bit of `evt_pulse` sets the matching flag, which stays set and reads at address 7; a write of any value to address 7 clears all flags, except that a pulse in the same cycle leaves its flag set.
- R12: The shadow resets to zero, so a write to address 1 alone after reset gives a CPU value of 0x00 in the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write enable for one cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, one cycle after the address |
| a_value | output | 20 | Register A to the device, alignment bits at the bottom |
| a_wstb | output | 1 | One-cycle pulse after a processor commit to A |
| a_dev_din | input | 16 | Device load value for A |
| a_dev_we | input | 1 | Device load enable for A |
| b_value | output | 12 | Register B to the device |
| b_wstb | output | 1 | One-cycle pulse after each processor byte write to B |
| status_i | input | 24 | Status value read by the processor |
| evt_pulse | input | 8 | Event pulses that set flags |

## Verification
The hardest situations to reach are coincidences on one clock edge: a commit of register A together with a device load, a flag clear together with a new pulse on the same flag, and a shadow byte written and then overtaken by device loads before the commit. Directed steps force each of these exactly once, and a long seeded random phase drives writes, reads, device loads and pulses in the same cycles at high rates so that such collisions recur in many orders. Every step is compared against a bench model of the map, the shadow and the flags.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
    localparam int BUS_W = 8;

    function automatic int nbytes(int width);
        return (width + BUS_W - 1) / BUS_W;
    endfunction
endpackage

// File: rtl/csrb_store.sv
module csrb_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ALIGN  = 0,
    parameter int BASE   = 0,
    parameter bit ATOMIC = 1'b0,
    parameter bit DEV_WR = 1'b0,
    parameter logic [DATA_W-1:0] RESET = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [7:0]              bus_wdata,
    input  logic [DATA_W-1:0]       dev_din,
    input  logic                    dev_we,
    output logic [DATA_W+ALIGN-1:0] value_o,
    output logic                    wstb_o,
    output logic [7:0]              rd_byte_o
);
    localparam int NBYTES = csrb_pkg::nbytes(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [DATA_W-1:0] shadow;
        logic              strobe;
    } st_t;

    st_t st_d, st_q;
    logic [NBYTES-1:0] hit;

    function automatic logic [DATA_W-1:0] put_byte(logic [DATA_W-1:0] v, int b, logic [7:0] d);
        for (int i = 0; i < DATA_W; i++) begin
            if (i / 8 == b) v[i] = d[i % 8];
        end
        return v;
    endfunction

    function automatic logic [7:0] get_byte(logic [DATA_W-1:0] v, int b);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < DATA_W; i++) begin
            if (i / 8 == b) r[i % 8] = v[i];
        end
        return r;
    endfunction

    // byte b (0 = least significant) lives at the highest address of the group
    for (genvar b = 0; b < NBYTES; b++) begin : g_hit
        assign hit[b] = (bus_addr == ADDR_W'(BASE + NBYTES - 1 - b));
    end

    always_comb begin
        logic [DATA_W-1:0] nv;
        logic [DATA_W-1:0] ns;
        logic              commit;
        nv     = st_q.value;
        ns     = st_q.shadow;
        commit = 1'b0;
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_we && hit[b]) begin
                if (ATOMIC) begin
                    if (b == 0) begin
                        nv     = put_byte(st_q.shadow, 0, bus_wdata);
                        commit = 1'b1;
                    end else begin
                        ns = put_byte(st_q.shadow, b, bus_wdata);
                    end
                end else begin
                    nv     = put_byte(st_q.value, b, bus_wdata);
                    commit = 1'b1;
                end
            end
        end
        st_d        = st_q;
        st_d.shadow = ns;
        st_d.strobe = commit;
        if (commit) begin
            st_d.value = nv;
        end else if (DEV_WR && dev_we) begin
            st_d.value = dev_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{value: RESET, shadow: '0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_byte_o = 8'h00;
        for (int b = 0; b < NBYTES; b++) begin
            if (hit[b]) rd_byte_o = get_byte(st_q.value, b);
        end
    end

    assign value_o = (DATA_W + ALIGN)'(st_q.value) << ALIGN;
    assign wstb_o  = st_q.strobe;
endmodule

// File: rtl/csrb_status.sv
module csrb_status #(
    parameter int ADDR_W = 4,
    parameter int STAT_W = 24,
    parameter int BASE   = 0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STAT_W-1:0] status_i,
    output logic [7:0]        rd_byte_o
);
    localparam int NBYTES = csrb_pkg::nbytes(STAT_W);

    always_comb begin
        rd_byte_o = 8'h00;
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_addr == ADDR_W'(BASE + NBYTES - 1 - b)) begin
                for (int i = 0; i < STAT_W; i++) begin
                    if (i / 8 == b) rd_byte_o[i % 8] = status_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/csrb_events.sv
module csrb_events #(
    parameter int ADDR_W = 4,
    parameter int EVT_N  = 8,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [EVT_N-1:0]  evt_pulse,
    output logic [EVT_N-1:0]  flags_o,
    output logic [7:0]        rd_byte_o
);
    typedef struct packed {
        logic [EVT_N-1:0] flags;
    } st_t;

    st_t  st_d, st_q;
    logic sel;

    assign sel = (bus_addr == ADDR_W'(BASE));

    always_comb begin
        st_d = st_q;
        if (bus_we && sel) st_d.flags = '0;
        st_d.flags = st_d.flags | evt_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o   = st_q.flags;
    assign rd_byte_o = sel ? 8'(st_q.flags) : 8'h00;
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
    parameter int ADDR_W  = 4,
    parameter int A_W     = 16,
    parameter int A_ALIGN = 4,
    parameter logic [A_W-1:0] A_RESET = 16'h1234,
    parameter int B_W     = 12,
    parameter logic [B_W-1:0] B_RESET = 12'h0A5,
    parameter int STAT_W  = 24,
    parameter int EVT_N   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic [A_W+A_ALIGN-1:0] a_value,
    output logic                   a_wstb,
    input  logic [A_W-1:0]         a_dev_din,
    input  logic                   a_dev_we,
    output logic [B_W-1:0]         b_value,
    output logic                   b_wstb,
    input  logic [STAT_W-1:0]      status_i,
    input  logic [EVT_N-1:0]       evt_pulse
);
    localparam int A_BYTES = csrb_pkg::nbytes(A_W);
    localparam int B_BYTES = csrb_pkg::nbytes(B_W);
    localparam int S_BYTES = csrb_pkg::nbytes(STAT_W);
    localparam int A_BASE  = 0;
    localparam int B_BASE  = A_BASE + A_BYTES;
    localparam int S_BASE  = B_BASE + B_BYTES;
    localparam int E_BASE  = S_BASE + S_BYTES;

    typedef struct packed {
        logic [7:0] rdata;
    } st_t;

    st_t        st_d, st_q;
    logic [7:0] a_rd, b_rd, s_rd, e_rd;
    logic [EVT_N-1:0] evt_flags;

    csrb_store #(
        .ADDR_W(ADDR_W), .DATA_W(A_W), .ALIGN(A_ALIGN), .BASE(A_BASE),
        .ATOMIC(1'b1), .DEV_WR(1'b1), .RESET(A_RESET)
    ) u_reg_a (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .dev_din(a_dev_din), .dev_we(a_dev_we),
        .value_o(a_value), .wstb_o(a_wstb), .rd_byte_o(a_rd)
    );

    csrb_store #(
        .ADDR_W(ADDR_W), .DATA_W(B_W), .ALIGN(0), .BASE(B_BASE),
        .ATOMIC(1'b0), .DEV_WR(1'b0), .RESET(B_RESET)
    ) u_reg_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .dev_din('0), .dev_we(1'b0),
        .value_o(b_value), .wstb_o(b_wstb), .rd_byte_o(b_rd)
    );

    csrb_status #(
        .ADDR_W(ADDR_W), .STAT_W(STAT_W), .BASE(S_BASE)
    ) u_status (
        .bus_addr(bus_addr), .status_i(status_i), .rd_byte_o(s_rd)
    );

    csrb_events #(
        .ADDR_W(ADDR_W), .EVT_N(EVT_N), .BASE(E_BASE)
    ) u_events (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .evt_pulse(evt_pulse), .flags_o(evt_flags), .rd_byte_o(e_rd)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = a_rd | b_rd | s_rd | e_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rdata: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
    parameter int ADDR_W  = 4,
    parameter int A_W     = 16,
    parameter int A_ALIGN = 4,
    parameter int B_W     = 12,
    parameter int EVT_N   = 8,
    parameter int A_LSB   = 1,
    parameter int B_BASE  = 2,
    parameter int E_BASE  = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [A_W+A_ALIGN-1:0] a_value,
    input logic                   a_wstb,
    input logic                   a_dev_we,
    input logic [B_W-1:0]         b_value,
    input logic [EVT_N-1:0]       evt_pulse,
    input logic [EVT_N-1:0]       evt_flags
);
    // R5
    a_stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_wstb |-> $past(bus_we && bus_addr == ADDR_W'(A_LSB)));

    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_value) |-> $past((bus_we && bus_addr == ADDR_W'(A_LSB)) || a_dev_we));

    // R9
    cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_LSB) && a_dev_we)
        |=> a_value[A_ALIGN+7:A_ALIGN] == $past(bus_wdata));

    // R7
    b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(B_BASE + 1)) |=> b_value[7:0] == $past(bus_wdata));

    // R3
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(E_BASE)) |=> bus_rdata == 8'h00);

    // R11
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(E_BASE)) |=> evt_flags == $past(evt_pulse));
endmodule

bind csr_bank csr_bank_chk #(
    .ADDR_W(ADDR_W), .A_W(A_W), .A_ALIGN(A_ALIGN), .B_W(B_W), .EVT_N(EVT_N),
    .A_LSB(A_BASE + A_BYTES - 1), .B_BASE(B_BASE), .E_BASE(E_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .a_value(a_value),
    .a_wstb(a_wstb), .a_dev_we(a_dev_we), .b_value(b_value),
    .evt_pulse(evt_pulse), .evt_flags(evt_flags)
);

// File: tb/csr_bank_tb.sv
`timescale 1ns/1ps
module csr_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [19:0] a_value;
    logic        a_wstb;
    logic [15:0] a_dev_din = '0;
    logic        a_dev_we = 1'b0;
    logic [11:0] b_value;
    logic        b_wstb;
    logic [23:0] status_i = '0;
    logic [7:0]  evt_pulse = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_a, m_sh;
    logic [11:0] m_b;
    logic [7:0]  m_fl;

    always #10 clk = ~clk;

    csr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .a_value(a_value),
        .a_wstb(a_wstb), .a_dev_din(a_dev_din), .a_dev_we(a_dev_we),
        .b_value(b_value), .b_wstb(b_wstb), .status_i(status_i),
        .evt_pulse(evt_pulse)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(logic [3:0] a);
        case (a)
            4'd0: return m_a[15:8];
            4'd1: return m_a[7:0];
            4'd2: return {4'h0, m_b[11:8]};
            4'd3: return m_b[7:0];
            4'd4: return status_i[23:16];
            4'd5: return status_i[15:8];
            4'd6: return status_i[7:0];
            4'd7: return m_fl;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(logic [3:0] a);
        if (a < 4'd4) return "R2";
        if (a < 4'd7) return "R10";
        if (a == 4'd7) return "R11";
        return "R3";
    endfunction

    // one bus cycle: drive at a falling edge, check at the next falling edge
    task automatic step(bit we, logic [3:0] a, logic [7:0] d, bit dwe,
                        logic [15:0] din, logic [7:0] pulse, string tag);
        logic [7:0] exp_rd;
        bit commit, exp_as, exp_bs;
        exp_rd = model_read(a);
        bus_we = we; bus_addr = a; bus_wdata = d;
        a_dev_we = dwe; a_dev_din = din; evt_pulse = pulse;
        commit = we && a == 4'd1;
        exp_as = commit;
        exp_bs = we && (a == 4'd2 || a == 4'd3);
        if (we) begin
            case (a)
                4'd0: m_sh[15:8] = d;
                4'd1: m_a = {m_sh[15:8], d};
                4'd2: m_b[11:8] = d[3:0];
                4'd3: m_b[7:0] = d;
                4'd7: m_fl = 8'h00;
                default: ;
            endcase
        end
        if (!commit && dwe) m_a = din;
        m_fl = m_fl | pulse;
        @(negedge clk);
        chk(bus_rdata == exp_rd, rd_tag(a), 32'(bus_rdata), 32'(exp_rd));
        chk(a_value == {m_a, 4'h0}, tag, 32'(a_value), 32'({m_a, 4'h0}));
        chk(b_value == m_b, tag, 32'(b_value), 32'(m_b));
        chk(a_wstb == exp_as, "R5", 32'(a_wstb), 32'(exp_as));
        chk(b_wstb == exp_bs, "R7", 32'(b_wstb), 32'(exp_bs));
    endtask

    task automatic idle(logic [3:0] a, string tag);
        step(1'b0, a, 8'h00, 1'b0, 16'h0, 8'h00, tag);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_a = 16'h1234; m_sh = 16'h0; m_b = 12'h0A5; m_fl = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(a_value == 20'h12340, "R1", 32'(a_value), 32'h12340);
        chk(b_value == 12'h0A5, "R1", 32'(b_value), 32'h0A5);
        chk(a_wstb == 1'b0 && b_wstb == 1'b0, "R1", 32'({a_wstb, b_wstb}), 32'h0);
        chk(bus_rdata == 8'h00, "R1", 32'(bus_rdata), 32'h0);
        @(negedge clk);
        idle(4'd7, "R1");
        // R12 shadow zero after reset
        step(1'b1, 4'd1, 8'h5A, 1'b0, 16'h0, 8'h00, "R12");
        idle(4'd0, "R12");
        // R4 atomic commit
        step(1'b1, 4'd0, 8'hC3, 1'b0, 16'h0, 8'h00, "R4");
        idle(4'd1, "R4");
        step(1'b1, 4'd1, 8'h3C, 1'b0, 16'h0, 8'h00, "R4");
        idle(4'd0, "R2");
        idle(4'd1, "R2");
        // R8 / R6 device load
        step(1'b0, 4'd0, 8'h00, 1'b1, 16'hFFFF, 8'h00, "R6");
        step(1'b0, 4'd0, 8'h00, 1'b1, 16'hBEEF, 8'h00, "R8");
        // R9 processor commit beats device load (shadow still 0xC3)
        step(1'b1, 4'd1, 8'h11, 1'b1, 16'h7777, 8'h00, "R9");
        idle(4'd0, "R9");
        // R7 byte-wise register
        step(1'b1, 4'd2, 8'hF9, 1'b0, 16'h0, 8'h00, "R7");
        step(1'b1, 4'd3, 8'h42, 1'b0, 16'h0, 8'h00, "R7");
        idle(4'd2, "R7");
        idle(4'd3, "R7");
        // R10 status read-only
        status_i = 24'hA1B2C3;
        idle(4'd4, "R10");
        step(1'b1, 4'd5, 8'hFF, 1'b0, 16'h0, 8'h00, "R10");
        idle(4'd5, "R10");
        idle(4'd6, "R10");
        // R11 event flags
        step(1'b0, 4'd0, 8'h00, 1'b0, 16'h0, 8'h05, "R11");
        idle(4'd7, "R11");
        step(1'b0, 4'd7, 8'h00, 1'b0, 16'h0, 8'h10, "R11");
        idle(4'd7, "R11");
        step(1'b1, 4'd7, 8'h00, 1'b0, 16'h0, 8'h02, "R11");
        idle(4'd7, "R11");
        step(1'b1, 4'd7, 8'hA5, 1'b0, 16'h0, 8'h00, "R11");
        idle(4'd7, "R11");
        // R3 unmapped
        step(1'b1, 4'd9, 8'h77, 1'b0, 16'h0, 8'h00, "R3");
        idle(4'd8, "R3");
        idle(4'd15, "R3");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ra;
            status_i = 24'($urandom);
            ra = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 8);
            step(($urandom % 2) == 0, ra, 8'($urandom), ($urandom % 4) == 0,
                 16'($urandom), ($urandom % 4 == 0) ? 8'($urandom) : 8'h00, "R4");
        end
        report();
    end
endmodule